// File: doc/BRIEF.md
# Programmable Multiplierless FIR Filter with Signed-Digit Recoding

This block is a direct-form finite impulse response filter with 18 taps and 10-bit signed samples. It accepts one sample on any clock where the input valid is high. For each accepted sample it delivers one full-precision result. There are no multipliers in the datapath. Each tap coefficient is held as an ordinary two's complement word and written through a simple address/data write port. Hardware recodes each coefficient into canonic signed-digit (CSD) form, where every digit is -1, 0 or +1 and no two neighbouring digits are non-zero.

Every non-zero digit turns into one partial product: the delayed sample shifted left by the digit position, and inverted when the digit is negative. The ones needed to complete those inversions are counted and added as one extra row. All rows from all taps go through one tree of 3:2 carry-save compressors and then one carry-propagate adder. As a result, the logic depth grows with the logarithm of the row count, not linearly with the number of taps.

The pipeline has three register stages: selected partial products, carry-save pair, and final sum. A result therefore follows its sample by a fixed three clock edges. Coefficients can be rewritten while the filter runs without disturbing the stored samples.

Top module: `csdFir`

## Requirements
- R1: After reset, outValid is 0 and outSample is 0. All coefficients read as zero, so the first results after reset are 0 whatever the samples are.
- R2: For each accepted sample x(n), the result equals the sum over k = 0..17 of h(k)·x(n-k). The result is exact as a 25-bit two's complement value. Samples accepted before reset count as 0.
- R3: A sample accepted at a rising edge E yields outValid = 1 with its result on outSample after edge E+2. The result is visible during the third clock period that starts after the sample was presented.
- R4: While inValid is 0, the delay line does not shift and no result is produced. outSample holds its last value while outValid is 0.
- R5: A write with coefWrEn = 1, address a and data d sets h(a) = d. Here d is 10-bit two's complement and h(a) weights the sample accepted a samples earlier: address 0 weights the newest sample.
- R6: A sample accepted at the same edge as a coefficient write still uses the old coefficient. Samples accepted at later edges use the new one.
- R7: Coefficient writes, whether the filter is idle or running, leave the stored samples unchanged.
- R8: A write to an address of 18 or above has no effect on any coefficient.
- R9: Coefficient values -512, 511, 0 and the alternating patterns 0101010101 (341) and 1010101010 (-342) give exact results, including for the extreme samples -512 and 511.
- R10: Every valid result lies within ±18·512·512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample qualifier; high accepts inSample at this edge |
| inSample | input | 10 | Signed input sample |
| coefWrEn | input | 1 | Coefficient write strobe |
| coefWrAddr | input | 5 | Tap index to write (0 = newest sample) |
| coefWrData | input | 10 | Signed two's complement coefficient |
| outValid | output | 1 | High when outSample carries a new result |
| outSample | output | 25 | Signed full-precision filter result |

## Verification
The bench builds the block with its default parameters: 18 taps and 10-bit samples and coefficients. At that size every one of the 1024 coefficient codes and every one of the 1024 sample codes can be swept in a few thousand cycles. The coefficient sweep writes every code into a rotating tap while samples are accepted in the same cycle, which exercises the recoder on every input and the same-edge write ordering. A behavioural convolution over the binary coefficients predicts every result, including all-extreme coefficient and sample runs, gapped valid patterns and idle writes.

// File: rtl/csdFirPkg.sv
package csdFirPkg;

  // One signed digit: nz marks a non-zero digit, neg makes it -1.
  typedef struct packed {
    logic nz;
    logic neg;
  } csdDigit_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic accept;    // shift delay line, capture partial products
    logic coefWe;    // legal coefficient write this cycle
    logic treeLoad;  // capture carry-save pair
    logic outLoad;   // capture final sum
  } firStrobe_t;

  // Number of 3:2 compression levels needed to reduce rows to two.
  function automatic int csaLevels(input int rows);
    int n;
    int lv;
    n = rows;
    lv = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      lv++;
    end
    return lv;
  endfunction

endpackage

// File: rtl/csdFirRecode.sv
module csdFirRecode
  import csdFirPkg::*;
#(
  parameter int CW = 10
) (
  input  logic [CW-1:0]     coef,
  output csdDigit_t [CW:0]  digits
);

  logic [CW+1:0] ext;
  logic          carry;

  // Scan from the LSB; a digit is non-zero where bit and carry differ.
  always_comb begin
    ext   = {coef[CW-1], coef[CW-1], coef};
    carry = 1'b0;
    for (int i = 0; i <= CW; i++) begin
      digits[i] = '0;
      if (ext[i] != carry) begin
        digits[i].nz  = 1'b1;
        digits[i].neg = ext[i+1];
        carry         = ext[i+1];
      end
    end
  end

endmodule

// File: rtl/csdFirCtrl.sv
module csdFirCtrl
  import csdFirPkg::*;
#(
  parameter int TAPS = 18,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          coefWrEn,
  input  logic [AW-1:0] coefWrAddr,
  output firStrobe_t    strobe,
  output logic          outValid
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
      outValid    <= stage2Valid;
    end
  end

  always_comb begin
    strobe.accept   = inValid;
    strobe.coefWe   = coefWrEn && (int'(coefWrAddr) < TAPS);
    strobe.treeLoad = stage1Valid;
    strobe.outLoad  = stage2Valid;
  end

endmodule

// File: rtl/csdFirDatapath.sv
module csdFirDatapath
  import csdFirPkg::*;
#(
  parameter int TAPS = 18,
  parameter int DW   = 10,
  parameter int CW   = 10,
  parameter int OW   = 25,
  parameter int AW   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  firStrobe_t           strobe,
  input  logic signed [DW-1:0] inSample,
  input  logic [AW-1:0]        coefWrAddr,
  input  logic [CW-1:0]        coefWrData,
  output logic signed [OW-1:0] outSample
);

  localparam int DIG    = CW + 1;
  localparam int NPP    = TAPS * DIG;
  localparam int NROWS  = NPP + 1;
  localparam int LEVELS = csaLevels(NROWS);

  logic signed [DW-1:0] delayLine [TAPS-1];
  logic signed [DW-1:0] tapSample [TAPS];
  logic [CW-1:0]        coefReg   [TAPS];
  logic [OW-1:0]        ppNext    [NROWS];
  logic [OW-1:0]        ppReg     [NROWS];
  logic [NPP-1:0]       negFlag;
  logic [OW-1:0]        treeSum;
  logic [OW-1:0]        treeCarry;
  logic [OW-1:0]        sumReg;
  logic [OW-1:0]        carryReg;

  // Delay line shifts only on accepted samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS - 1; k++) delayLine[k] <= '0;
    end else if (strobe.accept) begin
      delayLine[0] <= inSample;
      for (int k = 1; k < TAPS - 1; k++) delayLine[k] <= delayLine[k-1];
    end
  end

  // Coefficient bank, written independently of the delay line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) coefReg[k] <= '0;
    end else if (strobe.coefWe) begin
      coefReg[coefWrAddr] <= coefWrData;
    end
  end

  // Per tap: recode, then select one shifted row per digit.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    csdDigit_t [CW:0]     digits;
    logic signed [OW-1:0] wide;

    if (k == 0) begin : g_new
      assign tapSample[k] = inSample;
    end else begin : g_old
      assign tapSample[k] = delayLine[k-1];
    end

    assign wide = OW'(tapSample[k]);

    csdFirRecode #(.CW(CW)) u_recode (
      .coef   (coefReg[k]),
      .digits (digits)
    );

    for (genvar i = 0; i < DIG; i++) begin : g_digit
      logic [OW-1:0] shifted;
      assign shifted = wide << i;
      assign ppNext[k*DIG+i] = !digits[i].nz ? '0 :
                               (digits[i].neg ? ~shifted : shifted);
      assign negFlag[k*DIG+i] = digits[i].nz & digits[i].neg;
    end
  end

  // Completing ones for every inverted row, folded into one row.
  assign ppNext[NPP] = OW'($countones(negFlag));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NROWS; r++) ppReg[r] <= '0;
    end else if (strobe.accept) begin
      for (int r = 0; r < NROWS; r++) ppReg[r] <= ppNext[r];
    end
  end

  // Carry-save reduction: each level folds groups of three into two.
  logic [OW-1:0] work [NROWS];
  logic [OW-1:0] nxt  [NROWS];
  int            rowCount;
  int            groups;
  int            rest;

  always_comb begin
    work     = ppReg;
    rowCount = NROWS;
    groups   = 0;
    rest     = 0;
    for (int lv = 0; lv < LEVELS; lv++) begin
      groups = rowCount / 3;
      rest   = rowCount % 3;
      for (int r = 0; r < NROWS; r++) nxt[r] = '0;
      for (int g = 0; g < NROWS / 3; g++) begin
        if (g < groups) begin
          nxt[2*g]   = work[3*g] ^ work[3*g+1] ^ work[3*g+2];
          nxt[2*g+1] = ((work[3*g] & work[3*g+1]) |
                        (work[3*g] & work[3*g+2]) |
                        (work[3*g+1] & work[3*g+2])) << 1;
        end
      end
      for (int r = 0; r < 2; r++) begin
        if (r < rest) nxt[2*groups+r] = work[3*groups+r];
      end
      work     = nxt;
      rowCount = 2 * groups + rest;
    end
    treeSum   = work[0];
    treeCarry = work[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg   <= '0;
      carryReg <= '0;
    end else if (strobe.treeLoad) begin
      sumReg   <= treeSum;
      carryReg <= treeCarry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSample <= '0;
    end else if (strobe.outLoad) begin
      outSample <= sumReg + carryReg;
    end
  end

endmodule

// File: rtl/csdFir.sv
module csdFir
  import csdFirPkg::*;
#(
  parameter int TAPS = 18,
  parameter int DW   = 10,
  parameter int CW   = 10,
  parameter int AW   = $clog2(TAPS),
  parameter int OW   = DW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  input  logic                 coefWrEn,
  input  logic [AW-1:0]        coefWrAddr,
  input  logic [CW-1:0]        coefWrData,
  output logic                 outValid,
  output logic signed [OW-1:0] outSample
);

  firStrobe_t strobe;

  csdFirCtrl #(.TAPS(TAPS), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .coefWrEn   (coefWrEn),
    .coefWrAddr (coefWrAddr),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  csdFirDatapath #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inSample   (inSample),
    .coefWrAddr (coefWrAddr),
    .coefWrData (coefWrData),
    .outSample  (outSample)
  );

endmodule

// File: rtl/csdFirChk.sv
module csdFirChk #(
  parameter int TAPS = 18,
  parameter int DW   = 10,
  parameter int CW   = 10,
  parameter int OW   = 25
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 outValid,
  input logic signed [OW-1:0] outSample
);

  localparam longint MAXMAG = longint'(TAPS) * (64'sd1 <<< (DW - 1)) * (64'sd1 <<< (CW - 1));

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: first cycle out of reset carries no result
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outSample == '0));

  // R3: a result appears exactly three edges after its sample
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R4: output word holds while no result is flagged
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outSample));

  // R10: full-precision result never exceeds the extreme sum
  assert_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'(outSample) <= MAXMAG && longint'(outSample) >= -MAXMAG));

endmodule

bind csdFir csdFirChk #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .outValid  (outValid),
  .outSample (outSample)
);

// File: tb/csdFir_tb.sv
module csdFir_tb;

  localparam int TAPS = 18;
  localparam int DW   = 10;
  localparam int CW   = 10;
  localparam int AW   = 5;
  localparam int OW   = 25;
  localparam time CLK_PERIOD = 10ns;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] inSample = '0;
  logic                 coefWrEn = 1'b0;
  logic [AW-1:0]        coefWrAddr = '0;
  logic [CW-1:0]        coefWrData = '0;
  logic                 outValid;
  logic signed [OW-1:0] outSample;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  bit     monOn = 1'b0;
  bit     haveLast = 1'b0;
  longint lastOut = 0;
  string  phaseTag = "R2";
  int     coefM [TAPS];
  int     sampM [TAPS];
  longint expQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  csdFir u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSample   (inSample),
    .coefWrEn   (coefWrEn),
    .coefWrAddr (coefWrAddr),
    .coefWrData (coefWrData),
    .outValid   (outValid),
    .outSample  (outSample)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle and advance the reference model.
  task automatic step(input bit v, input int x, input bit we, input int addr, input int data);
    longint acc;
    int xs;
    int cd;
    inValid    = v;
    inSample   = DW'(x);
    coefWrEn   = we;
    coefWrAddr = AW'(addr);
    coefWrData = CW'(data);
    xs = int'($signed(inSample));
    cd = int'($signed(coefWrData));
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) sampM[k] = sampM[k-1];
      sampM[0] = xs;
      acc = 0;
      for (int k = 0; k < TAPS; k++) acc += longint'(coefM[k]) * longint'(sampM[k]);
      expQ.push_back(acc);
    end
    if (we && addr >= 0 && addr < TAPS) coefM[addr] = cd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0);
  endtask

  task automatic setAll(input int c);
    for (int k = 0; k < TAPS; k++) step(1'b0, 0, 1'b1, k, c);
  endtask

  // Compare every result against the convolution; check hold on idle.
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, phaseTag, longint'(outSample), 0);
        end else begin
          longint e;
          e = expQ.pop_front();
          check(longint'(outSample) == e, phaseTag, longint'(outSample), e);
        end
        lastOut  = longint'(outSample);
        haveLast = 1'b1;
      end else if (haveLast) begin
        check(longint'(outSample) == lastOut, "R4 hold", longint'(outSample), lastOut);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      coefM[k] = 0;
      sampM[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(outValid == 1'b0, "R1 outValid", longint'(outValid), 0);
    check(outSample == '0, "R1 outSample", longint'(outSample), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 after release", longint'(outValid), 0);
    monOn = 1'b1;

    // R1: coefficients start at zero
    phaseTag = "R1 zero coefficients";
    for (int i = 0; i < 20; i++) step(1'b1, (i * 97) - 300, 1'b0, 0, 0);
    idle(4);

    // R3: one isolated sample; count negedges until its result
    phaseTag = "R3 latency";
    begin
      int seenAt;
      seenAt = 0;
      step(1'b1, 200, 1'b0, 0, 0);
      if (outValid && seenAt == 0) seenAt = 1;
      for (int i = 2; i <= 5; i++) begin
        step(1'b0, 0, 1'b0, 0, 0);
        if (outValid && seenAt == 0) seenAt = i;
      end
      check(seenAt == 3, "R3 edges to result", seenAt, 3);
    end

    // R9: extreme coefficients with extreme samples
    phaseTag = "R9 R2 coef -512";
    setAll(-512);
    for (int i = 0; i < 20; i++) step(1'b1, -512, 1'b0, 0, 0);
    for (int i = 0; i < 20; i++) step(1'b1, 511, 1'b0, 0, 0);
    for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? 511 : -512, 1'b0, 0, 0);
    phaseTag = "R9 R2 coef 511";
    setAll(511);
    for (int i = 0; i < 20; i++) step(1'b1, -512, 1'b0, 0, 0);
    for (int i = 0; i < 20; i++) step(1'b1, 511, 1'b0, 0, 0);
    phaseTag = "R9 R2 coef 0";
    setAll(0);
    for (int i = 0; i < 20; i++) step(1'b1, 511, 1'b0, 0, 0);

    // R9: alternating bit patterns, every sample code
    phaseTag = "R9 R2 alternating";
    for (int k = 0; k < TAPS; k++) step(1'b0, 0, 1'b1, k, (k % 2) ? -342 : 341);
    for (int x = -512; x < 512; x++) step(1'b1, x, 1'b0, 0, 0);

    // R5 R6: every coefficient code, written in the same cycle as a sample
    phaseTag = "R5 R6 coef sweep";
    for (int c = -512; c < 512; c++) step(1'b1, (c * 73) + 5, 1'b1, (c + 512) % TAPS, c);
    idle(4);

    // R4 R7: gapped valid with writes in idle and busy cycles
    phaseTag = "R4 R7 gaps";
    begin
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      for (int i = 0; i < 600; i++) begin
        bit v;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        v = lfsr[0];
        step(v, (i * 211) - 500, lfsr[2] & lfsr[6], i % TAPS, (i * 37) - 400);
      end
    end
    idle(4);

    // R8: out-of-range writes leave every coefficient alone
    phaseTag = "R8 ignored address";
    for (int a = TAPS; a < 32; a++) step(1'b0, 0, 1'b1, a, 511);
    for (int i = 0; i < 40; i++) step(1'b1, (i * 131) - 512, 1'b0, 0, 0);
    idle(5);

    check(expQ.size() == 0, "R2 all results delivered", expQ.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule